// File: doc/BRIEF.md
# Multi-Channel PRBS Bit-Error Checker

This block is a built-in self-test checker for a six-channel receive path. Each channel hands it a 10-bit received word with a strobe and a lock indication. A test run can cover a single channel or all of them. While the test runs, every channel that is not selected keeps passing its live traffic and lock status straight through. The run is switched on and off by a filtered activate input. The channel choice is captured at the moment the run turns on.

A channel under test drives its lock output low. It checks each strobed word against a PRBS-15 sequence that it regenerates locally. The generator locks onto the incoming stream by loading itself from the first two words it receives. Errors are reported on that channel's own data outputs in one of two ways: a sticky all-ones flag, or a flag per bit position for each word. Once a set number of words has been checked, the channel latches a completion flag and a pass/fail verdict into a 12-bit result vector.

Top module: `bist_err_checker`

## Requirements
- R1: The internal test-active state changes only after `act_in` has held the opposite level for DEB (default 4) consecutive clock edges. A shorter pulse, in either direction, has no effect.
- R2: `ch_sel` is captured on the edge at which the test turns on. Codes 0 to 5 select that one channel, code 6 selects all channels, and code 7 selects none. While the test is off, no channel is under test.
- R3: Every channel under test drives `lock_n_out` low (0) for as long as the test stays active.
- R4: With `bit_mode` low (gross mode), the first checked word that contains any error drives all 10 data outputs of that channel to 1. They stay at 1 until the test is switched off.
- R5: With `bit_mode` high, each data output bit of a tested channel is 1 exactly when that bit position was in error in the most recent checked word. The flags are recomputed on every strobed word.
- R6: A channel that is not under test outputs `rx_word` and `lock_n_in` unchanged, in the same cycle.
- R7: The expected stream follows s[n] = s[n-14] XOR s[n-15]. Bit 0 of each word is the earliest bit. The first two strobed words after activation seed the generator and are not checked, and words without a strobe are ignored.
- R8: When RUN_WORDS words have been checked, the channel sets its done flag. The pass flag is set when the total number of erroneous bits is at or below ERR_LIMIT.
- R9: `result` bit 2c+1 is the done flag of channel c and bit 2c is its pass flag. All bits are 0 after reset.
- R10: Every result bit clears on the edge at which a new test run turns on. The bits keep their values when the test is switched off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_in | input | 1 | Test activate request, filtered |
| ch_sel | input | 3 | Channel select code |
| bit_mode | input | 1 | 0 = gross error report, 1 = per-bit report |
| rx_word | input | 60 | Received words, channel c at bits [10c+9:10c] |
| rx_stb | input | 6 | Word valid strobe per channel |
| lock_n_in | input | 6 | Lock status from the front end, low = locked |
| dout | output | 60 | Data or error flags per channel |
| lock_n_out | output | 6 | Lock status out, forced low under test |
| result | output | 12 | Done and pass flags per channel |

## Verification
The assertions take two things for granted about the inputs. First, the two words that seed a tested channel are error-free PRBS words, because an error in a seed word would put the generator out of step with the stream. Second, the stream on each channel is one continuous PRBS-15 sequence that advances only on strobed words. The stimulus keeps within both rules. Its per-channel generators advance only when the strobe is driven. It also holds back any error injection on a tested channel until the reference model has seen both seed words. Select codes, mode and activate pulses of various lengths are otherwise driven freely.

// File: rtl/bist_err_checker.sv
module bist_err_checker #(
  parameter int NCH = 6,
  parameter int W = 10,
  parameter int DEB = 4,
  parameter int RUN_WORDS = 1000000,
  parameter int ERR_LIMIT = 1,
  localparam int SW = $clog2(NCH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_in,
  input  logic [SW-1:0]     ch_sel,
  input  logic              bit_mode,
  input  logic [NCH*W-1:0]  rx_word,
  input  logic [NCH-1:0]    rx_stb,
  input  logic [NCH-1:0]    lock_n_in,
  output logic [NCH*W-1:0]  dout,
  output logic [NCH-1:0]    lock_n_out,
  output logic [2*NCH-1:0]  result
);
  localparam int DW = $clog2(DEB + 1);
  localparam int CW = $clog2(RUN_WORDS + 1);
  localparam int EW = $clog2(ERR_LIMIT + W + 2);

  logic          act_q;
  logic [DW-1:0] deb_cnt;
  logic [SW-1:0] sel_q;

  wire flip  = (act_in != act_q) && (deb_cnt == DW'(DEB - 1));
  wire start = flip && !act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      deb_cnt <= '0;
      sel_q   <= '0;
    end else if (act_in != act_q) begin
      if (flip) begin
        act_q   <= ~act_q;
        deb_cnt <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
      if (start) sel_q <= ch_sel;
    end else begin
      deb_cnt <= '0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [14:0]   hist, hnext;
    logic [1:0]    seen;
    logic [CW-1:0] nwords;
    logic [EW-1:0] nerr;
    logic [W-1:0]  errq, expw;
    logic          done, pass;

    wire [W-1:0] word = rx_word[c*W +: W];
    wire ten = act_q && (sel_q == SW'(c) || sel_q == SW'(NCH));
    wire seeding = seen < 2'd2;

    always_comb begin
      hnext = hist;
      expw  = '0;
      for (int i = 0; i < W; i++) begin
        expw[i] = hnext[0] ^ hnext[1];
        hnext   = {seeding ? word[i] : expw[i], hnext[14:1]};
      end
    end

    wire [W-1:0]  mism     = word ^ expw;
    wire [EW-1:0] nerr_sum = nerr + EW'($countones(mism));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist <= '0; seen <= '0; nwords <= '0; nerr <= '0;
        errq <= '0; done <= 1'b0; pass <= 1'b0;
      end else if (start) begin
        seen <= '0; nwords <= '0; nerr <= '0;
        errq <= '0; done <= 1'b0; pass <= 1'b0;
      end else if (ten && rx_stb[c]) begin
        hist <= hnext;
        if (seeding) begin
          seen <= seen + 2'd1;
        end else begin
          errq <= bit_mode ? mism : ((|errq || |mism) ? '1 : '0);
          if (!done) begin
            nwords <= nwords + 1'b1;
            nerr   <= (nerr_sum > EW'(ERR_LIMIT)) ? EW'(ERR_LIMIT + 1) : nerr_sum;
            if (nwords == CW'(RUN_WORDS - 1)) begin
              done <= 1'b1;
              pass <= nerr_sum <= EW'(ERR_LIMIT);
            end
          end
        end
      end
    end

    assign dout[c*W +: W] = ten ? errq : word;
    assign lock_n_out[c]  = ten ? 1'b0 : lock_n_in[c];
    assign result[2*c+1]  = done;
    assign result[2*c]    = pass;
  end
endmodule

// File: rtl/bist_err_checker_sva.sv
module bist_err_checker_sva #(
  parameter int NCH = 6,
  parameter int W = 10,
  parameter int DEB = 4,
  parameter int SW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act_in,
  input logic             act_q,
  input logic [SW-1:0]    sel_q,
  input logic             bit_mode,
  input logic [NCH*W-1:0] rx_word,
  input logic [NCH-1:0]   lock_n_in,
  input logic [NCH*W-1:0] dout,
  input logic [NCH-1:0]   lock_n_out,
  input logic [2*NCH-1:0] result
);
  int hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= act_in ? ((hi_run < DEB) ? hi_run + 1 : hi_run) : 0;
      lo_run <= !act_in ? ((lo_run < DEB) ? lo_run + 1 : lo_run) : 0;
    end
  end

  a_r1_on_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> hi_run >= DEB);
  a_r1_off_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> lo_run >= DEB);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    wire tst = act_q && (sel_q == SW'(c) || sel_q == SW'(NCH));
    wire [W-1:0] d = dout[c*W +: W];

    a_r3_lock_low: assert property (@(posedge clk) disable iff (!rst_n)
      tst |-> lock_n_out[c] == 1'b0);
    a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !tst |-> (d == rx_word[c*W +: W]) && (lock_n_out[c] == lock_n_in[c]));
    a_r4_gross_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tst && !bit_mode && (&d)) |=> (!tst || (&d)));
    a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      result[2*c] |-> result[2*c+1]);
    a_r10_done_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(result[2*c+1]) |-> $rose(act_q));
  end
endmodule

bind bist_err_checker bist_err_checker_sva #(.NCH(NCH), .W(W), .DEB(DEB), .SW(SW)) u_sva (
  .clk(clk), .rst_n(rst_n), .act_in(act_in), .act_q(act_q), .sel_q(sel_q),
  .bit_mode(bit_mode), .rx_word(rx_word), .lock_n_in(lock_n_in), .dout(dout),
  .lock_n_out(lock_n_out), .result(result)
);

// File: tb/bist_err_checker_tb.sv
module bist_err_checker_tb;
  localparam int NCH = 6, W = 10, DEB = 4, RUNW = 40, LIM = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, act_in = 1'b0, bit_mode = 1'b0;
  logic [2:0] ch_sel = '0;
  logic [NCH*W-1:0] rx_word = '0, dout;
  logic [NCH-1:0] rx_stb = '0, lock_n_in = '1, lock_n_out;
  logic [2*NCH-1:0] result;

  bist_err_checker #(.NCH(NCH), .W(W), .DEB(DEB), .RUN_WORDS(RUNW), .ERR_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_in(act_in), .ch_sel(ch_sel), .bit_mode(bit_mode),
    .rx_word(rx_word), .rx_stb(rx_stb), .lock_n_in(lock_n_in), .dout(dout),
    .lock_n_out(lock_n_out), .result(result));

  int n_run = 0, n_fail = 0, cyc = 0;
  bit m_act; int m_cnt, m_sel;
  int m_seen[NCH], m_words[NCH], m_errs[NCH];
  logic [W-1:0] m_eo[NCH], inj[NCH], cur_err[NCH];
  bit m_done[NCH], m_pass[NCH];
  int tx[NCH];
  bit stb_rand = 0;

  task automatic check(string tag, logic [63:0] a, logic [63:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic bit tested(int c);
    return m_act && (m_sel == c || m_sel == NCH);
  endfunction

  task automatic gen_word(int c, output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      int b;
      b = ((tx[c] >> 14) ^ (tx[c] >> 13)) & 1;
      w[i] = b[0];
      tx[c] = ((tx[c] << 1) | b) & 32'h7fff;
    end
  endtask

  always @(negedge clk) begin : model
    bit en [NCH];
    bit start;
    string tag;
    logic [W-1:0] ew;
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_sel = 0;
      for (int c = 0; c < NCH; c++) begin
        m_seen[c] = 0; m_words[c] = 0; m_errs[c] = 0; m_eo[c] = '0;
        m_done[c] = 0; m_pass[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) en[c] = tested(c);
      start = 0;
      if (act_in != m_act) begin
        m_cnt++;
        if (m_cnt == DEB) begin
          m_act = !m_act; m_cnt = 0;
          if (m_act) begin start = 1; m_sel = int'(ch_sel); end
        end
      end else m_cnt = 0;
      for (int c = 0; c < NCH; c++) begin
        if (start) begin
          m_seen[c] = 0; m_words[c] = 0; m_errs[c] = 0; m_eo[c] = '0;
          m_done[c] = 0; m_pass[c] = 0;
        end else if (en[c] && rx_stb[c]) begin
          if (m_seen[c] < 2) m_seen[c]++;
          else begin
            m_eo[c] = bit_mode ? cur_err[c] : ((m_eo[c] != 0 || cur_err[c] != 0) ? '1 : '0);
            if (!m_done[c]) begin
              m_words[c]++;
              m_errs[c] += $countones(cur_err[c]);
              if (m_words[c] == RUNW) begin m_done[c] = 1; m_pass[c] = (m_errs[c] <= LIM); end
            end
          end
        end
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (tested(c)) begin
        tag = bit_mode ? "R5 per-bit flags" : "R4 gross flags";
        check(tag, 64'(dout[c*W +: W]), 64'(m_eo[c]));
        check("R3 lock low under test", 64'(lock_n_out[c]), 64'd0);
      end else begin
        check("R6 data passthrough", 64'(dout[c*W +: W]), 64'(rx_word[c*W +: W]));
        check("R6 lock passthrough", 64'(lock_n_out[c]), 64'(lock_n_in[c]));
      end
      check("R9 result flags", 64'(result[2*c +: 2]), 64'({m_done[c], m_pass[c]}));
    end
    for (int c = 0; c < NCH; c++) begin
      bit s;
      s = stb_rand ? bit'($urandom_range(0, 1)) : 1'b1;
      rx_stb[c] = s;
      cur_err[c] = '0;
      if (s) begin
        gen_word(c, ew);
        if (inj[c] != 0 && !(tested(c) && m_seen[c] < 2)) begin
          cur_err[c] = inj[c]; inj[c] = '0;
        end
        rx_word[c*W +: W] = ew ^ cur_err[c];
      end
    end
    lock_n_in = NCH'($urandom);
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin tx[c] = 32'h1 + c * 32'h123; inj[c] = '0; cur_err[c] = '0; end
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    check("R9 reset result zero", 64'(result), 64'd0);
    // R1: short pulse ignored
    act_in = 1'b1; ch_sel = 3'd2;
    wait_n(3);
    act_in = 1'b0;
    wait_n(3);
    check("R1 short pulse ignored", 64'(lock_n_out), 64'(lock_n_in));
    // run on channel 2, gross mode
    act_in = 1'b1;
    wait_n(8);
    check("R1 R3 active after filter", 64'(lock_n_out[2]), 64'd0);
    check("R2 single channel only", 64'(lock_n_out[1]), 64'(lock_n_in[1]));
    check("R7 clean stream no flags", 64'(dout[2*W +: W]), 64'd0);
    wait_n(8);
    inj[2] = 10'h004;
    wait_n(3);
    check("R4 gross all ones", 64'(dout[2*W +: W]), 64'h3ff);
    wait_n(10);
    check("R4 gross sticky", 64'(dout[2*W +: W]), 64'h3ff);
    wait_n(40);
    check("R8 R7 done and pass", 64'(result[5:4]), 64'd3);
    act_in = 1'b0;
    wait_n(2);
    check("R1 still active during filter", 64'(lock_n_out[2]), 64'd0);
    wait_n(4);
    check("R1 R6 released", 64'(dout[2*W +: W]), 64'(rx_word[2*W +: W]));
    check("R10 result kept after off", 64'(result[5:4]), 64'd3);
    // run on all channels, per-bit mode
    bit_mode = 1'b1; ch_sel = 3'd6; act_in = 1'b1;
    wait_n(8);
    check("R10 result cleared on start", 64'(result), 64'd0);
    check("R2 all channels tested", 64'(lock_n_out), 64'd0);
    inj[0] = 10'h081;
    @(negedge clk); @(negedge clk); #1;
    check("R5 bit flags match error", 64'(dout[W-1:0]), 64'h081);
    wait_n(1);
    check("R5 flags cleared next word", 64'(dout[W-1:0]), 64'd0);
    inj[0] = 10'h00f;
    wait_n(2);
    inj[5] = 10'h200;
    stb_rand = 1;
    wait_n(200);
    check("R8 channel 0 fails", 64'(result[1:0]), 64'd2);
    check("R8 channel 5 passes", 64'(result[11:10]), 64'd3);
    check("R7 clean channel passes", 64'(result[7:6]), 64'd3);
    act_in = 1'b0;
    wait_n(8);
    // idle code
    ch_sel = 3'd7; act_in = 1'b1;
    wait_n(10);
    check("R2 idle code passthrough", 64'(dout), 64'(rx_word));
    check("R2 idle code lock", 64'(lock_n_out), 64'(lock_n_in));
    check("R10 idle start clears", 64'(result), 64'd0);
    act_in = 1'b0;
    wait_n(8);
    // gross mode on all, with random strobes
    bit_mode = 1'b0; ch_sel = 3'd6; act_in = 1'b1;
    wait_n(20);
    inj[3] = 10'h100;
    wait_n(30);
    check("R4 gross sticky under gaps", 64'(dout[3*W +: W]), 64'h3ff);
    act_in = 1'b0;
    wait_n(2);
    act_in = 1'b1;
    wait_n(6);
    check("R1 off pulse ignored", 64'(lock_n_out[3]), 64'd0);
    act_in = 1'b0;
    wait_n(8);
    check("R6 all released", 64'(lock_n_out), 64'(lock_n_in));
    summary();
  end
endmodule